// File: doc/BRIEF.md
# Shift-Rotate Unit With Carry

A purely combinational 16-bit shift and rotate unit for the execute stage of a small processor datapath. It takes one operand, a 4-bit count (0 to 15 positions), a carry input and a 3-bit operation code. It returns the shifted or rotated word together with a carry-out and an overflow-out, which the surrounding datapath writes into its status flags.

The count may come from a constant field of an instruction or from the low bits of a register, so every count value is a normal operating case. Two of the eight operations rotate through the carry, treating it as a seventeenth bit of the word.

Internally, left operations are handled by bit-reversing the operand, running one shared right funnel shifter built from logarithmic stages, and reversing the result back. No state machine, register, reset or clock is involved.

Top module: `sru_shift_rotate`

## Requirements
- R1: Operation codes 000 (shift left) and 010 (arithmetic shift left) both give `opnd_i << amount_i`, truncated to 16 bits, with zeros entering at the LSB.
- R2: Code 001 (logical shift right) gives `opnd_i >> amount_i`, with zeros entering at the MSB.
- R3: Code 011 (arithmetic shift right) gives the operand shifted right, with copies of bit 15 entering at the MSB, so result bit 15 always equals operand bit 15.
- R4: Code 100 rotates the 16-bit word left by the count and code 101 rotates it right. The number of set bits is unchanged.
- R5: Codes 110 and 111 rotate the 17-bit value {carry_i, opnd_i} left and right. The new carry is bit 16 of the rotated value and the result is bits 15:0.
- R6: With a count of zero, every operation returns the operand unchanged, carry_o equals carry_i and ovf_o is 0.
- R7: With a nonzero count, carry_o is the last bit moved out of the word: operand bit 16-n for left operations and operand bit n-1 for right operations.
- R8: ovf_o is 1 exactly when a left operation (codes 000, 010, 100, 110) with a nonzero count changes bit 15. It is always 0 for right operations (codes 001, 011, 101, 111).
- R9: For codes 000 to 101 with a nonzero count, carry_i has no effect on result_o or carry_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 16 | Operand word |
| amount_i | input | 4 | Number of positions to move, 0 to 15 |
| carry_i | input | 1 | Carry flag in |
| op_i | input | 3 | Operation code |
| result_o | output | 16 | Shifted or rotated word |
| carry_o | output | 1 | Carry flag out |
| ovf_o | output | 1 | Overflow flag out |

## Verification
The block holds no state, so a fault in any funnel stage, in the frame selection or in the reversal shows up at the ports in the same evaluation as the inputs that reach it. A stage fault appears only for counts with the matching bit set. A wrong fill word shows only for certain operations and operand sign bits. For these reasons, every operation code is swept against every count and both carry values over a set of operands that includes the corner words. A wrong carry or overflow tap becomes visible one count at a time, so each of the three outputs is compared separately against an arithmetic model.

// File: rtl/sru_pkg.sv
package sru_pkg;

    typedef enum logic [2:0] {
        OP_SHL = 3'b000,
        OP_SHR = 3'b001,
        OP_SAL = 3'b010,
        OP_SAR = 3'b011,
        OP_ROL = 3'b100,
        OP_ROR = 3'b101,
        OP_RCL = 3'b110,
        OP_RCR = 3'b111
    } sru_op_e;

    // Left-moving operations have a zero in the low code bit.
    function automatic logic op_is_left(input sru_op_e op);
        return ~op[0];
    endfunction

endpackage

// File: rtl/sru_reverse.sv
module sru_reverse #(
    parameter int W = 16
) (
    input  logic         en_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] flipped;

    for (genvar i = 0; i < W; i++) begin : g_flip
        assign flipped[i] = d_i[W-1-i];
    end

    assign q_o = en_i ? flipped : d_i;
endmodule

// File: rtl/sru_frame.sv
module sru_frame
    import sru_pkg::*;
#(
    parameter int W = 16,
    localparam int M = W + 1
) (
    input  sru_op_e        op_i,
    input  logic [W-1:0]   word_i,   // already reversed for left operations
    input  logic           msb_i,    // original operand bit W-1
    input  logic           carry_i,
    output logic [2*M-1:0] frame_o
);
    logic [M-1:0] fill;

    always_comb begin
        unique case (op_i)
            OP_SHL, OP_SAL, OP_SHR: fill = '0;
            OP_SAR:                 fill = {M{msb_i}};
            OP_ROL, OP_ROR:         fill = {1'b0, word_i};
            OP_RCL, OP_RCR:         fill = {word_i, carry_i};
            default:                fill = '0;
        endcase
    end

    assign frame_o = {fill, word_i, carry_i};
endmodule

// File: rtl/sru_funnel.sv
module sru_funnel #(
    parameter int W = 16,
    localparam int M  = W + 1,
    localparam int CW = $clog2(W)
) (
    input  logic [2*M-1:0] frame_i,
    input  logic [CW-1:0]  amount_i,
    output logic [M-1:0]   low_o
);
    logic [2*M-1:0] stage [CW+1];

    assign stage[0] = frame_i;

    for (genvar k = 0; k < CW; k++) begin : g_stage
        assign stage[k+1] = amount_i[k] ? (stage[k] >> (1 << k)) : stage[k];
    end

    logic unused_hi;
    assign unused_hi = ^stage[CW][2*M-1:M];

    assign low_o = stage[CW][M-1:0];
endmodule

// File: rtl/sru_shift_rotate.sv
module sru_shift_rotate
    import sru_pkg::*;
#(
    parameter int W = 16,
    localparam int M  = W + 1,
    localparam int CW = $clog2(W)
) (
    input  logic [W-1:0]  opnd_i,
    input  logic [CW-1:0] amount_i,
    input  logic          carry_i,
    input  logic [2:0]    op_i,
    output logic [W-1:0]  result_o,
    output logic          carry_o,
    output logic          ovf_o
);
    sru_op_e        op;
    logic           left;
    logic [W-1:0]   word_in;
    logic [2*M-1:0] frame;
    logic [M-1:0]   low;
    logic [W-1:0]   word_out;

    assign op   = sru_op_e'(op_i);
    assign left = op_is_left(op);

    sru_reverse #(.W(W)) u_rev_in (
        .en_i (left),
        .d_i  (opnd_i),
        .q_o  (word_in)
    );

    sru_frame #(.W(W)) u_frame (
        .op_i    (op),
        .word_i  (word_in),
        .msb_i   (opnd_i[W-1]),
        .carry_i (carry_i),
        .frame_o (frame)
    );

    sru_funnel #(.W(W)) u_funnel (
        .frame_i  (frame),
        .amount_i (amount_i),
        .low_o    (low)
    );

    sru_reverse #(.W(W)) u_rev_out (
        .en_i (left),
        .d_i  (low[M-1:1]),
        .q_o  (word_out)
    );

    assign result_o = word_out;
    assign carry_o  = low[0];
    assign ovf_o    = left && (amount_i != '0) && (word_out[W-1] != opnd_i[W-1]);

    always_comb begin
        if (amount_i == '0) begin
            p_zero_count_r6: assert (result_o == opnd_i && carry_o == carry_i && !ovf_o);
        end
        if (op_i[0]) begin
            p_no_overflow_r8: assert (!ovf_o);
        end
        if (op_i == 3'b011) begin
            p_sign_kept_r3: assert (result_o[W-1] == opnd_i[W-1]);
        end
        if (op_i == 3'b100 || op_i == 3'b101) begin
            p_rot_bits_r4: assert ($countones(result_o) == $countones(opnd_i));
        end
        if (op_i == 3'b110 || op_i == 3'b111) begin
            p_rcx_bits_r5: assert ($countones({carry_o, result_o}) == $countones({carry_i, opnd_i}));
        end
        if ((op_i == 3'b000 || op_i == 3'b010) && amount_i != '0) begin
            p_shl_lsb_r1: assert (result_o[0] == 1'b0);
        end
        if (op_i == 3'b001 && amount_i != '0) begin
            p_shr_msb_r2: assert (result_o[W-1] == 1'b0);
        end
    end
endmodule

// File: tb/sru_shift_rotate_test.sv
module sru_shift_rotate_test;
    logic        clk = 1'b0;
    logic [15:0] opnd;
    logic [3:0]  amount;
    logic        cin;
    logic [2:0]  op;
    logic [15:0] result;
    logic        cout;
    logic        ovf;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sru_shift_rotate uut (
        .opnd_i   (opnd),
        .amount_i (amount),
        .carry_i  (cin),
        .op_i     (op),
        .result_o (result),
        .carry_o  (cout),
        .ovf_o    (ovf)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s op=%0d n=%0d a=%h c=%0d: actual=%h expected=%h",
                     req, op, amount, opnd, cin, act, exp);
        end
    endtask

    function automatic string op_req(input int o);
        case (o)
            0, 2:    return "R1";
            1:       return "R2";
            3:       return "R3";
            4, 5:    return "R4";
            default: return "R5";
        endcase
    endfunction

    // Arithmetic model of all eight operations.
    task automatic model(input int o, input int a, input int n, input int c,
                         output int r, output int co, output int ov);
        int v, v2, sa;
        r = a; co = c; ov = 0;
        if (n != 0) begin
            case (o)
                0, 2: begin r = (a << n) & 16'hFFFF; co = (a >> (16 - n)) & 1; end
                1:    begin r = a >> n; co = (a >> (n - 1)) & 1; end
                3:    begin
                          sa = (a & 16'h8000) != 0 ? (a | 32'hFFFF0000) : a;
                          r  = (sa >>> n) & 16'hFFFF;
                          co = (a >> (n - 1)) & 1;
                      end
                4:    begin r = ((a << n) | (a >> (16 - n))) & 16'hFFFF; co = r & 1; end
                5:    begin r = ((a >> n) | (a << (16 - n))) & 16'hFFFF; co = (r >> 15) & 1; end
                6:    begin
                          v  = (c << 16) | a;
                          v2 = ((v << n) | (v >> (17 - n))) & 17'h1FFFF;
                          r  = v2 & 16'hFFFF; co = (v2 >> 16) & 1;
                      end
                default: begin
                          v  = (c << 16) | a;
                          v2 = ((v >> n) | (v << (17 - n))) & 17'h1FFFF;
                          r  = v2 & 16'hFFFF; co = (v2 >> 16) & 1;
                      end
            endcase
            if ((o % 2) == 0) ov = ((r ^ a) >> 15) & 1;
        end
    endtask

    function automatic logic [15:0] pattern(input int i);
        logic [15:0] s;
        case (i)
            0: return 16'h0000;
            1: return 16'hFFFF;
            2: return 16'h8000;
            3: return 16'h0001;
            4: return 16'h7FFF;
            5: return 16'hAAAA;
            6: return 16'h5555;
            7: return 16'h8001;
            default: begin
                s = 16'hACE1;
                for (int k = 0; k < i; k++) s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
                return s;
            end
        endcase
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int er, ec, ev, r0, c0;
        opnd = '0; amount = '0; cin = 1'b0; op = '0;
        #1;
        check("R6 idle", int'(result), 0);
        check("R6 idle", int'(cout), 0);
        check("R8 idle", int'(ovf), 0);

        for (int p = 0; p < 40; p++) begin
            for (int o = 0; o < 8; o++) begin
                for (int n = 0; n < 16; n++) begin
                    for (int c = 0; c < 2; c++) begin
                        @(negedge clk);
                        opnd = pattern(p); op = 3'(o); amount = 4'(n); cin = 1'(c);
                        #1;
                        model(o, int'(opnd), n, c, er, ec, ev);
                        if (n == 0) begin
                            check("R6 result", int'(result), er);
                            check("R6 carry", int'(cout), ec);
                        end else begin
                            check(op_req(o), int'(result), er);
                            check("R7 carry", int'(cout), ec);
                        end
                        check("R8 overflow", int'(ovf), ev);
                    end
                end
            end
        end

        // R9: carry_i must not alter non-carry operations at nonzero counts.
        for (int o = 0; o < 6; o++) begin
            for (int n = 1; n < 16; n++) begin
                @(negedge clk);
                opnd = 16'hB38D; op = 3'(o); amount = 4'(n); cin = 1'b0;
                #1;
                r0 = int'(result); c0 = int'(cout);
                cin = 1'b1;
                #1;
                check("R9 result", int'(result), r0);
                check("R9 carry", int'(cout), c0);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule